// File: doc/BRIEF.md
# Interconnect Test Pattern Sequencer

This block drives a set of board nets with a sequence of parallel test vectors and reads back what each net actually carried. Across the sequence every net receives a serial code word, one bit per vector. When the sequence ends, the block compares the code each net returned against the code it was given. Four coding families can be selected at launch: binary counting, counting that skips the all-zero and all-one words, a true phase followed by a complement phase, and a walking one.

The fault model assumes two kinds of defect. An open net reads as a constant 0. Nets shorted together read as the AND of their drivers. Any net whose returned code differs from its assigned code is flagged as failing. A failing net whose returned code exactly matches that of another failing net is flagged as a suspected short. The board loop is expected to settle within one clock: the value on `sense` is sampled at the same edge that retires the vector shown on `drive`.

Top module: `ict_pattern_sequencer`

## Requirements
- R1: During and right after reset, `drive`, `vec_idx`, `busy`, `done`, `net_fail` and `net_short` are all zero, and `drive` stays zero whenever `busy` is low.
- R2: Mode 0 (counting): at step k, net i is driven with bit k of the binary value i. The run lasts ceil(log2(NETS)) steps.
- R3: Mode 1 (modified counting): at step k, net i is driven with bit k of i+1. The run lasts ceil(log2(NETS+2)) steps, so no net is ever given the all-zero or all-one word.
- R4: Mode 2 (true/complement): for the first C = ceil(log2(NETS)) steps, net i carries bit k of i. For the next C steps it carries the inverse of bit k-C of i. The run lasts 2*C steps.
- R5: Mode 3 (walking): at step k only net k is driven 1, so exactly one net is high per step. The run lasts NETS steps.
- R6: The returned code of net i holds, at bit k, the `sense[i]` value sampled while `vec_idx` equals k. After the run, `net_fail[i]` is 1 exactly when that returned code differs from the assigned code.
- R7: `net_short[i]` is 1 exactly when net i fails and at least one other failing net returned an identical code.
- R8: On the clock edge that retires the last vector, `drive` returns to zero. One clock later, `done` rises, `busy` falls and the results become valid. `done` and the results then hold until the next start.
- R9: A start pulse has effect only while idle. A start pulse during a run, or a change on `mode` during a run, does not alter the vector sequence or the results.
- R10: `vec_idx` shows the step of the vector currently on `drive`. It begins at 0, rises by one per clock during a run, and keeps the final step value after the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| mode | input | 2 | Code family: 0 counting, 1 modified counting, 2 true/complement, 3 walking |
| sense | input | NETS | Values read back from the nets for the current vector |
| drive | output | NETS | Registered test vector applied to the nets |
| vec_idx | output | IDX_W | Step index of the vector on `drive` |
| busy | output | 1 | High from launch until the results are written |
| done | output | 1 | High once the results are valid |
| net_fail | output | NETS | Per-net mismatch between returned and assigned code |
| net_short | output | NETS | Per-net suspected short: failing, with a twin failing signature |

## Verification
The bench runs every code family against a clean board and against boards with opens and with two-net and three-net shorts. One open is placed on net 0, whose counting code is all zeros. A design that did not treat that case as undetectable would flag a good net there. The bench also adds an open alongside a short. This catches a short detector that pairs any two failing nets instead of only nets with matching signatures. A launch pulse and a mode change are injected in the middle of a run. A design that restarted, or that read `mode` live, would show a wrong vector at the next step. Every vector and its index are compared step by step, so an off-by-one sequence length or a misplaced complement phase shows up at the exact step where it first goes wrong.

// File: rtl/ict_pkg.sv
package ict_pkg;

  typedef enum logic [1:0] {
    CODE_COUNT    = 2'd0,
    CODE_MODCOUNT = 2'd1,
    CODE_TRUECOMP = 2'd2,
    CODE_WALK     = 2'd3
  } code_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EVAL = 2'd2
  } seq_state_e;

  // Bit that net 'net' carries at step 'step' for the selected family.
  // base_len is the counting length used by the complement phase.
  function automatic logic code_bit(code_mode_e m, int net, int step, int base_len);
    logic b;
    case (m)
      CODE_COUNT:    b = ((net >> step) & 1) != 0;
      CODE_MODCOUNT: b = (((net + 1) >> step) & 1) != 0;
      CODE_TRUECOMP: b = (step < base_len) ? (((net >> step) & 1) != 0)
                                           : (((net >> (step - base_len)) & 1) == 0);
      default:       b = (net == step);
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ict_vector_gen.sv
module ict_vector_gen
  import ict_pkg::*;
#(
  parameter int NETS    = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_LEN = 3
) (
  input  code_mode_e       mode,
  input  logic [IDX_W-1:0] step,
  output logic [NETS-1:0]  vec
);

  for (genvar gi = 0; gi < NETS; gi++) begin : g_net
    assign vec[gi] = code_bit(mode, gi, int'(step), CNT_LEN);
  end

endmodule

// File: rtl/ict_signature_store.sv
module ict_signature_store #(
  parameter int NETS  = 8,
  parameter int SIG_W = 8,
  parameter int IDX_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear,
  input  logic                        cap_en,
  input  logic [IDX_W-1:0]            cap_idx,
  input  logic [NETS-1:0]             sense,
  output logic [NETS-1:0][SIG_W-1:0]  sig
);

  for (genvar gi = 0; gi < NETS; gi++) begin : g_net
    logic [SIG_W-1:0] code_q;

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        code_q <= '0;
      end else if (cap_en) begin
        code_q[cap_idx] <= sense[gi];
      end
    end

    assign sig[gi] = code_q;
  end

endmodule

// File: rtl/ict_fault_analyzer.sv
module ict_fault_analyzer
  import ict_pkg::*;
#(
  parameter int NETS    = 8,
  parameter int SIG_W   = 8,
  parameter int LEN_W   = 4,
  parameter int CNT_LEN = 3
) (
  input  code_mode_e                  mode,
  input  logic [LEN_W-1:0]            len,
  input  logic [NETS-1:0][SIG_W-1:0]  sig,
  output logic [NETS-1:0]             fail,
  output logic [NETS-1:0]             suspect
);

  for (genvar gi = 0; gi < NETS; gi++) begin : g_cmp
    logic [SIG_W-1:0] want;

    always_comb begin
      for (int k = 0; k < SIG_W; k++) begin
        want[k] = (k < int'(len)) ? code_bit(mode, gi, k, CNT_LEN) : 1'b0;
      end
    end

    assign fail[gi] = (sig[gi] != want);
  end

  for (genvar gi = 0; gi < NETS; gi++) begin : g_pair
    logic twin;

    always_comb begin
      twin = 1'b0;
      for (int j = 0; j < NETS; j++) begin
        if ((j != gi) && fail[j] && (sig[j] == sig[gi])) begin
          twin = 1'b1;
        end
      end
    end

    assign suspect[gi] = fail[gi] & twin;
  end

endmodule

// File: rtl/ict_pattern_sequencer.sv
module ict_pattern_sequencer
  import ict_pkg::*;
#(
  parameter  int NETS    = 8,
  localparam int CNT_LEN = $clog2(NETS),
  localparam int MOD_LEN = $clog2(NETS + 2),
  localparam int TC_LEN  = 2 * CNT_LEN,
  localparam int BIG_A   = (NETS > TC_LEN) ? NETS : TC_LEN,
  localparam int SIG_W   = (BIG_A > MOD_LEN) ? BIG_A : MOD_LEN,
  localparam int IDX_W   = $clog2(SIG_W),
  localparam int LEN_W   = $clog2(SIG_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [NETS-1:0]  sense,
  output logic [NETS-1:0]  drive,
  output logic [IDX_W-1:0] vec_idx,
  output logic             busy,
  output logic             done,
  output logic [NETS-1:0]  net_fail,
  output logic [NETS-1:0]  net_short
);

  seq_state_e       state_q;
  code_mode_e       mode_q;
  logic [IDX_W-1:0] idx_q;
  logic [NETS-1:0]  drive_q;
  logic             done_q;
  logic [NETS-1:0]  fail_q;
  logic [NETS-1:0]  short_q;

  logic             run_st;
  logic             eval_st;
  logic             launch;
  logic             last_step;
  logic [LEN_W-1:0] seq_len_c;
  code_mode_e       gen_mode;
  logic [IDX_W-1:0] gen_step;
  logic [NETS-1:0]  gen_vec;
  logic [NETS-1:0][SIG_W-1:0] sig;
  logic [NETS-1:0]  fail_c;
  logic [NETS-1:0]  short_c;

  assign run_st  = (state_q == ST_RUN);
  assign eval_st = (state_q == ST_EVAL);
  assign launch  = (state_q == ST_IDLE) && start;

  always_comb begin
    case (mode_q)
      CODE_COUNT:    seq_len_c = LEN_W'(CNT_LEN);
      CODE_MODCOUNT: seq_len_c = LEN_W'(MOD_LEN);
      CODE_TRUECOMP: seq_len_c = LEN_W'(TC_LEN);
      default:       seq_len_c = LEN_W'(NETS);
    endcase
  end

  assign last_step = ((LEN_W'(idx_q) + LEN_W'(1)) == seq_len_c);
  assign gen_mode  = launch ? code_mode_e'(mode) : mode_q;
  assign gen_step  = launch ? '0 : (idx_q + IDX_W'(1));

  ict_vector_gen #(
    .NETS    (NETS),
    .IDX_W   (IDX_W),
    .CNT_LEN (CNT_LEN)
  ) u_vec (
    .mode (gen_mode),
    .step (gen_step),
    .vec  (gen_vec)
  );

  ict_signature_store #(
    .NETS  (NETS),
    .SIG_W (SIG_W),
    .IDX_W (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .clear   (launch),
    .cap_en  (run_st),
    .cap_idx (idx_q),
    .sense   (sense),
    .sig     (sig)
  );

  ict_fault_analyzer #(
    .NETS    (NETS),
    .SIG_W   (SIG_W),
    .LEN_W   (LEN_W),
    .CNT_LEN (CNT_LEN)
  ) u_check (
    .mode    (mode_q),
    .len     (seq_len_c),
    .sig     (sig),
    .fail    (fail_c),
    .suspect (short_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= CODE_COUNT;
      idx_q   <= '0;
      drive_q <= '0;
      done_q  <= 1'b0;
      fail_q  <= '0;
      short_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            mode_q  <= code_mode_e'(mode);
            idx_q   <= '0;
            drive_q <= gen_vec;
            done_q  <= 1'b0;
            fail_q  <= '0;
            short_q <= '0;
          end
        end
        ST_RUN: begin
          if (last_step) begin
            state_q <= ST_EVAL;
            drive_q <= '0;
          end else begin
            idx_q   <= gen_step;
            drive_q <= gen_vec;
          end
        end
        ST_EVAL: begin
          state_q <= ST_IDLE;
          fail_q  <= fail_c;
          short_q <= short_c;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drive     = drive_q;
  assign vec_idx   = idx_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign net_fail  = fail_q;
  assign net_short = short_q;

endmodule

// File: rtl/ict_sequencer_checker.sv
module ict_sequencer_checker
  import ict_pkg::*;
#(
  parameter int NETS  = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             run_st,
  input logic             eval_st,
  input code_mode_e       mode_q,
  input logic [NETS-1:0]  drive,
  input logic [IDX_W-1:0] vec_idx,
  input logic             busy,
  input logic             done,
  input logic [NETS-1:0]  net_fail,
  input logic [NETS-1:0]  net_short
);

  // R1: nets stay undriven outside a run
  a_r1_idle_drive_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (drive == '0));

  // R5: walking vectors carry a single high net
  a_r5_walk_single: assert property (@(posedge clk) disable iff (rst)
    (run_st && (mode_q == CODE_WALK)) |-> ($countones(drive) == 1));

  // R7: a suspected short is always also a failing net
  a_r7_short_in_fail: assert property (@(posedge clk) disable iff (rst)
    ((net_short & ~net_fail) == '0));

  // R8: results are written one clock after the last vector retires
  a_r8_eval_done: assert property (@(posedge clk) disable iff (rst)
    eval_st |=> (done && !busy));

  // R8: done never overlaps a run
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9: the latched family holds for the whole run
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
    run_st |=> $stable(mode_q));

  // R10: step index advances by one while the run continues
  a_r10_idx_step: assert property (@(posedge clk) disable iff (rst)
    run_st |=> (!run_st || (vec_idx == ($past(vec_idx) + IDX_W'(1)))));

endmodule

bind ict_pattern_sequencer ict_sequencer_checker #(
  .NETS  (NETS),
  .IDX_W (IDX_W)
) u_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .run_st    (run_st),
  .eval_st   (eval_st),
  .mode_q    (mode_q),
  .drive     (drive),
  .vec_idx   (vec_idx),
  .busy      (busy),
  .done      (done),
  .net_fail  (net_fail),
  .net_short (net_short)
);

// File: tb/ict_pattern_sequencer_bench.sv
`timescale 1ns/1ps
module ict_pattern_sequencer_bench;

  localparam int NETS  = 8;
  localparam int CNT   = $clog2(NETS);
  localparam int MODL  = $clog2(NETS + 2);
  localparam int SIG_W = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             start;
  logic [1:0]       mode;
  logic [NETS-1:0]  sense;
  logic [NETS-1:0]  drive;
  logic [IDX_W-1:0] vidx;
  logic             busy;
  logic             done;
  logic [NETS-1:0]  nfail;
  logic [NETS-1:0]  nshort;

  logic [NETS-1:0]       open_m;
  logic [NETS-1:0][3:0]  grp;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  function automatic logic [NETS-1:0] board(logic [NETS-1:0] v,
                                            logic [NETS-1:0] op,
                                            logic [NETS-1:0][3:0] g);
    logic [NETS-1:0] s;
    for (int i = 0; i < NETS; i++) begin
      if (op[i]) s[i] = 1'b0;
      else if (g[i] != 4'd0) begin
        s[i] = 1'b1;
        for (int j = 0; j < NETS; j++) if (g[j] == g[i]) s[i] = s[i] & v[j];
      end else s[i] = v[i];
    end
    return s;
  endfunction

  assign sense = board(drive, open_m, grp);

  ict_pattern_sequencer #(.NETS(NETS)) u_ict_pattern_sequencer (
    .clk (clk), .rst (rst), .start (start), .mode (mode), .sense (sense),
    .drive (drive), .vec_idx (vidx), .busy (busy), .done (done),
    .net_fail (nfail), .net_short (nshort)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int seq_len(int m);
    case (m)
      0: return CNT;
      1: return MODL;
      2: return 2 * CNT;
      default: return NETS;
    endcase
  endfunction

  function automatic bit exp_bit(int m, int i, int k);
    case (m)
      0: return ((i >> k) & 1) == 1;
      1: return (((i + 1) >> k) & 1) == 1;
      2: return (k < CNT) ? (((i >> k) & 1) == 1) : (((i >> (k - CNT)) & 1) == 0);
      default: return i == k;
    endcase
  endfunction

  function automatic logic [NETS-1:0] exp_vec(int m, int k);
    logic [NETS-1:0] v;
    for (int i = 0; i < NETS; i++) v[i] = exp_bit(m, i, k);
    return v;
  endfunction

  task automatic set_fault(int sc);
    open_m = '0;
    grp    = '0;
    case (sc)
      1: open_m[3] = 1'b1;
      2: open_m[0] = 1'b1;
      3: begin grp[1] = 4'd1; grp[2] = 4'd1; end
      4: begin grp[0] = 4'd1; grp[5] = 4'd1; open_m[6] = 1'b1; end
      5: begin grp[2] = 4'd2; grp[4] = 4'd2; grp[7] = 4'd2; end
      default: ;
    endcase
  endtask

  task automatic run_case(int m, bit disturb);
    logic [NETS-1:0][SIG_W-1:0] rc;
    logic [NETS-1:0][SIG_W-1:0] ec;
    logic [NETS-1:0] ef;
    logic [NETS-1:0] es;
    logic [NETS-1:0] s;
    int L;
    string tag;
    L  = seq_len(m);
    rc = '0;
    ec = '0;
    for (int k = 0; k < L; k++) begin
      s = board(exp_vec(m, k), open_m, grp);
      for (int i = 0; i < NETS; i++) begin
        rc[i][k] = s[i];
        ec[i][k] = exp_bit(m, i, k);
      end
    end
    for (int i = 0; i < NETS; i++) ef[i] = (rc[i] != ec[i]);
    for (int i = 0; i < NETS; i++) begin
      es[i] = 1'b0;
      for (int j = 0; j < NETS; j++)
        if (j != i && ef[i] && ef[j] && rc[i] == rc[j]) es[i] = 1'b1;
    end
    case (m)
      0: tag = "R2";
      1: tag = "R3";
      2: tag = "R4";
      default: tag = "R5";
    endcase
    if (disturb) tag = "R9";

    @(negedge clk);
    mode  = 2'(m);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < L; k++) begin
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      check(drive == exp_vec(m, k), tag, $sformatf("vector step %0d", k),
            longint'(drive), longint'(exp_vec(m, k)));
      check(vidx == IDX_W'(k), "R10", "step index", longint'(vidx), longint'(k));
      if (disturb && k == 0) begin
        start = 1'b1;
        mode  = 2'((m + 1) % 4);
      end
      if (disturb && k == 1) start = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(drive == '0, "R8", "drive after last vector", longint'(drive), 0);
    check(done == 1'b0, "R8", "done one clock early", longint'(done), 0);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b1, "R8", "done raised", longint'(done), 1);
    check(busy == 1'b0, "R8", "busy cleared", longint'(busy), 0);
    check(nfail == ef, "R6", $sformatf("fail map mode %0d", m), longint'(nfail), longint'(ef));
    check(nshort == es, "R7", $sformatf("short map mode %0d", m), longint'(nshort), longint'(es));
    check(vidx == IDX_W'(L - 1), "R10", "final index", longint'(vidx), longint'(L - 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst    = 1'b1;
    start  = 1'b0;
    mode   = 2'd0;
    open_m = '0;
    grp    = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(drive == '0, "R1", "reset drive", longint'(drive), 0);
    check(vidx == '0, "R1", "reset index", longint'(vidx), 0);
    check(busy == 1'b0, "R1", "reset busy", longint'(busy), 0);
    check(done == 1'b0, "R1", "reset done", longint'(done), 0);
    check(nfail == '0, "R1", "reset fail", longint'(nfail), 0);
    check(nshort == '0, "R1", "reset short", longint'(nshort), 0);
    rst = 1'b0;
    @(negedge clk);
    check(drive == '0 && !busy, "R1", "idle after reset", longint'(drive), 0);

    for (int sc = 0; sc < 6; sc++) begin
      set_fault(sc);
      for (int m = 0; m < 4; m++) run_case(m, 1'b0);
    end

    set_fault(3);
    run_case(0, 1'b1);
    set_fault(5);
    run_case(2, 1'b1);
    set_fault(0);
    run_case(3, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule